// File: doc/BRIEF.md
# Serial Port Interrupt Request Controller

This block keeps the interrupt request flags of one multi-mode serial channel and steers a set of shared interrupt lines. A receive request flag rises when the receive buffer fills. Whether a receive overrun also raises it depends on the 3-bit channel mode. A transmit request is formed from the channel's transmit events, including the special start-up path of the smart-card (SIM) mode.

Each shared line has a select bit that decides which of two sources may set its flag. Line 0 is shared between this channel's transmit request and its start/stop-condition or bus-collision detector. Lines 1 and up are shared between the transmit requests of peer channels and other peripherals. A select value of 0 always picks the serial source. Software clears any flag with a one-cycle strobe. This lets it discard the spurious requests that mode reconfiguration can leave behind.

All flags are registered. An event seen at a rising clock edge shows on the outputs right after that edge.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After reset `rx_irq`, `vec_irq`, `mode_rd` and `sel_rd` are all zero.
- R2: A 0-to-1 change of `rx_full` sets `rx_irq` one cycle later. Once `rx_irq` is cleared, a `rx_full` that simply stays high does not set it again.
- R3: When `mode_rd` is not 3'b010, a strobe on `rx_ovr` leaves `rx_irq` unchanged.
- R4: When `mode_rd` equals 3'b010 (I2C mode), a strobe on `rx_ovr` sets `rx_irq` one cycle later.
- R5: `clr_rx` clears `rx_irq` and `clr_vec[i]` clears `vec_irq[i]` one cycle later. A write to the mode register leaves every flag unchanged.
- R6: If a set event and a clear strobe for the same flag come in the same cycle, the flag is 1 afterwards.
- R7: With `sel_rd[0]`=0, a transmit event sets `vec_irq[0]` and `cond_ev` is ignored. A transmit event is `tx_en` high together with `tx_cmplt` (when `txc_sel`=1) or with `tx_empty` (when `txc_sel`=0).
- R8: With `sel_rd[0]`=1, `cond_ev` sets `vec_irq[0]` and transmit events are ignored.
- R9: For a line i of 1 or more, `peer_tx_ev[i-1]` sets `vec_irq[i]` when `sel_rd[i]`=0, and `periph_ev[i-1]` sets it when `sel_rd[i]`=1. The unselected source is ignored.
- R10: In SIM mode (`mode_rd`=3'b101), a `tx_buf_wr` strobe with `txc_sel`, `err_out` and `tx_en` all high is a transmit event. In any other mode, or with any of those three inputs low, `tx_buf_wr` alone is not.
- R11: With `tx_en` low, `tx_empty` and `tx_cmplt` produce no transmit event.
- R12: Changing a select bit neither sets nor clears the flag of its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 3 | New channel mode |
| sel_we | input | 1 | Write strobe for the select register |
| sel_wdata | input | NVEC | New source-select bits |
| rx_full | input | 1 | Receive buffer holds data (level) |
| rx_ovr | input | 1 | Overrun strobe: data arrived while buffer full |
| tx_en | input | 1 | Transmitter enabled |
| txc_sel | input | 1 | 1: request on transmit complete, 0: on buffer empty |
| err_out | input | 1 | Error-signal output enabled (SIM) |
| tx_buf_wr | input | 1 | Strobe: software wrote the transmit buffer |
| tx_empty | input | 1 | Strobe: transmit buffer moved to the shifter |
| tx_cmplt | input | 1 | Strobe: last bit shifted out |
| cond_ev | input | 1 | Strobe: start/stop condition or bus collision |
| peer_tx_ev | input | NVEC-1 | Transmit strobes of peer channels, lines 1 and up |
| periph_ev | input | NVEC-1 | Other peripheral strobes, lines 1 and up |
| clr_rx | input | 1 | Clear strobe for the receive flag |
| clr_vec | input | NVEC | Clear strobes for the shared-line flags |
| rx_irq | output | 1 | Receive request flag |
| vec_irq | output | NVEC | Shared-line request flags |
| mode_rd | output | 3 | Current channel mode |
| sel_rd | output | NVEC | Current source-select bits |

## Verification
The bench raises overruns in an ordinary mode and in I2C mode. A design that ignored the mode would either miss I2C overruns or raise requests a normal receiver never sees. It holds `rx_full` high after a clear to catch a level-sensitive detector that fires again at once. It also lines up a clear with a fresh event, since a wrong priority loses that interrupt. On the shared lines it drives the unselected source and toggles the select bits. This catches a swapped or stuck multiplexer, or a select write that wipes or raises a flag. Last, it walks the SIM start-up path with each enable bit missing in turn, and once outside SIM mode.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_I2C = 3'b010;
    localparam logic [MODE_W-1:0] MODE_SIM = 3'b101;

    function automatic logic is_i2c(input logic [MODE_W-1:0] m);
        return m == MODE_I2C;
    endfunction

    function automatic logic is_sim(input logic [MODE_W-1:0] m);
        return m == MODE_SIM;
    endfunction
endpackage

// File: rtl/sio_rx_req.sv
module sio_rx_req
    import sio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_edge,
    input  logic              ovr,
    input  logic [MODE_W-1:0] mode,
    input  logic              clr,
    output logic              irq
);
    typedef struct packed {
        logic flag;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   set_ev;

    always_comb begin
        set_ev = full_edge | (ovr & is_i2c(mode));
        st_d   = st_q;
        if (set_ev)
            st_d.flag = 1'b1;
        else if (clr)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.flag;
endmodule

// File: rtl/sio_tx_evt.sv
module sio_tx_evt
    import sio_irq_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              tx_en,
    input  logic              txc_sel,
    input  logic              err_out,
    input  logic              tx_buf_wr,
    input  logic              tx_empty,
    input  logic              tx_cmplt,
    output logic              tx_ev
);
    logic norm_ev;
    logic sim_ev;

    always_comb begin
        norm_ev = tx_en & (txc_sel ? tx_cmplt : tx_empty);
        sim_ev  = is_sim(mode) & txc_sel & err_out & tx_en & tx_buf_wr;
        tx_ev   = norm_ev | sim_ev;
    end
endmodule

// File: rtl/sio_vec_flag.sv
module sio_vec_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic ser_ev,
    input  logic alt_ev,
    input  logic clr,
    output logic irq
);
    typedef struct packed {
        logic flag;
    } vf_st_t;

    vf_st_t st_d, st_q;
    logic   set_ev;

    always_comb begin
        set_ev = sel ? alt_ev : ser_ev;
        st_d   = st_q;
        if (set_ev)
            st_d.flag = 1'b1;
        else if (clr)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.flag;
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
    import sio_irq_pkg::*;
#(
    parameter int NVEC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              sel_we,
    input  logic [NVEC-1:0]   sel_wdata,
    input  logic              rx_full,
    input  logic              rx_ovr,
    input  logic              tx_en,
    input  logic              txc_sel,
    input  logic              err_out,
    input  logic              tx_buf_wr,
    input  logic              tx_empty,
    input  logic              tx_cmplt,
    input  logic              cond_ev,
    input  logic [NVEC-2:0]   peer_tx_ev,
    input  logic [NVEC-2:0]   periph_ev,
    input  logic              clr_rx,
    input  logic [NVEC-1:0]   clr_vec,
    output logic              rx_irq,
    output logic [NVEC-1:0]   vec_irq,
    output logic [MODE_W-1:0] mode_rd,
    output logic [NVEC-1:0]   sel_rd
);
    localparam int NPEER = NVEC - 1;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [NVEC-1:0]   sel;
        logic              rx_full_q;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    full_edge;
    logic    own_tx_ev;
    logic [NVEC-1:0] ser_src;
    logic [NVEC-1:0] alt_src;

    always_comb begin
        st_d           = st_q;
        st_d.rx_full_q = rx_full;
        if (mode_we) st_d.mode = mode_wdata;
        if (sel_we)  st_d.sel  = sel_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_edge = rx_full & ~st_q.rx_full_q;

    sio_rx_req u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_edge (full_edge),
        .ovr       (rx_ovr),
        .mode      (st_q.mode),
        .clr       (clr_rx),
        .irq       (rx_irq)
    );

    sio_tx_evt u_tx (
        .mode      (st_q.mode),
        .tx_en     (tx_en),
        .txc_sel   (txc_sel),
        .err_out   (err_out),
        .tx_buf_wr (tx_buf_wr),
        .tx_empty  (tx_empty),
        .tx_cmplt  (tx_cmplt),
        .tx_ev     (own_tx_ev)
    );

    assign ser_src[0] = own_tx_ev;
    assign alt_src[0] = cond_ev;

    generate
        for (genvar p = 0; p < NPEER; p++) begin : g_peer
            assign ser_src[p+1] = peer_tx_ev[p];
            assign alt_src[p+1] = periph_ev[p];
        end
        for (genvar v = 0; v < NVEC; v++) begin : g_vec
            sio_vec_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .sel    (st_q.sel[v]),
                .ser_ev (ser_src[v]),
                .alt_ev (alt_src[v]),
                .clr    (clr_vec[v]),
                .irq    (vec_irq[v])
            );
        end
    endgenerate

    assign mode_rd = st_q.mode;
    assign sel_rd  = st_q.sel;
endmodule

// File: rtl/sio_irq_ctrl_chk.sv
module sio_irq_ctrl_chk
    import sio_irq_pkg::*;
#(
    parameter int NVEC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_full,
    input logic              rx_full_prev,
    input logic              rx_ovr,
    input logic              clr_rx,
    input logic              rx_irq,
    input logic [MODE_W-1:0] mode_rd,
    input logic [NVEC-1:0]   sel_rd,
    input logic              cond_ev,
    input logic              tx_en,
    input logic              txc_sel,
    input logic              err_out,
    input logic              tx_buf_wr,
    input logic              tx_empty,
    input logic              tx_cmplt,
    input logic [NVEC-1:0]   vec_irq
);
    AST_RX_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_full_prev) |=> rx_irq); // R2

    AST_OVR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_irq && rx_ovr && mode_rd != MODE_I2C && !(rx_full && !rx_full_prev)) |=> !rx_irq); // R3

    AST_I2C_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr && mode_rd == MODE_I2C) |=> rx_irq); // R4

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rx && !rx_ovr && !(rx_full && !rx_full_prev)) |=> !rx_irq); // R5

    AST_VEC0_ALT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rd[0] && cond_ev) |=> vec_irq[0]); // R8

    AST_VEC0_ALT_BLOCKS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rd[0] && !cond_ev && !vec_irq[0]) |=> !vec_irq[0]); // R8

    AST_SIM_TX_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_rd[0] && mode_rd == MODE_SIM && txc_sel && err_out && tx_en && tx_buf_wr) |=> vec_irq[0]); // R10

    AST_TX_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_rd[0] && !tx_en && !vec_irq[0]) |=> !vec_irq[0]); // R11

    AST_TX_CMPLT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_rd[0] && tx_en && ((txc_sel && tx_cmplt) || (!txc_sel && tx_empty))) |=> vec_irq[0]); // R7
endmodule

bind sio_irq_ctrl sio_irq_ctrl_chk #(.NVEC(NVEC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_full      (rx_full),
    .rx_full_prev (st_q.rx_full_q),
    .rx_ovr       (rx_ovr),
    .clr_rx       (clr_rx),
    .rx_irq       (rx_irq),
    .mode_rd      (mode_rd),
    .sel_rd       (sel_rd),
    .cond_ev      (cond_ev),
    .tx_en        (tx_en),
    .txc_sel      (txc_sel),
    .err_out      (err_out),
    .tx_buf_wr    (tx_buf_wr),
    .tx_empty     (tx_empty),
    .tx_cmplt     (tx_cmplt),
    .vec_irq      (vec_irq)
);

// File: tb/sio_irq_ctrl_tb.sv
module sio_irq_ctrl_tb;
    localparam int NVEC = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode_we = 0;
    logic [2:0]      mode_wdata = 0;
    logic            sel_we = 0;
    logic [NVEC-1:0] sel_wdata = 0;
    logic            rx_full = 0, rx_ovr = 0;
    logic            tx_en = 0, txc_sel = 0, err_out = 0;
    logic            tx_buf_wr = 0, tx_empty = 0, tx_cmplt = 0, cond_ev = 0;
    logic [NVEC-2:0] peer_tx_ev = 0, periph_ev = 0;
    logic            clr_rx = 0;
    logic [NVEC-1:0] clr_vec = 0;
    logic            rx_irq;
    logic [NVEC-1:0] vec_irq;
    logic [2:0]      mode_rd;
    logic [NVEC-1:0] sel_rd;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    sio_irq_ctrl #(.NVEC(NVEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .sel_we(sel_we), .sel_wdata(sel_wdata), .rx_full(rx_full), .rx_ovr(rx_ovr),
        .tx_en(tx_en), .txc_sel(txc_sel), .err_out(err_out), .tx_buf_wr(tx_buf_wr),
        .tx_empty(tx_empty), .tx_cmplt(tx_cmplt), .cond_ev(cond_ev),
        .peer_tx_ev(peer_tx_ev), .periph_ev(periph_ev), .clr_rx(clr_rx),
        .clr_vec(clr_vec), .rx_irq(rx_irq), .vec_irq(vec_irq),
        .mode_rd(mode_rd), .sel_rd(sel_rd)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [2:0] m);
        mode_we = 1; mode_wdata = m; tick(); mode_we = 0;
    endtask

    task automatic set_sel(input logic [NVEC-1:0] s);
        sel_we = 1; sel_wdata = s; tick(); sel_we = 0;
    endtask

    task automatic clear_all();
        clr_rx = 1; clr_vec = '1; tick(); clr_rx = 0; clr_vec = '0;
    endtask

    task automatic t_reset();
        check("R1 rx_irq", 8'(rx_irq), 0);
        check("R1 vec_irq", 8'(vec_irq), 0);
        check("R1 mode_rd", 8'(mode_rd), 0);
        check("R1 sel_rd", 8'(sel_rd), 0);
    endtask

    task automatic t_rx_edge();
        rx_full = 1; tick();
        check("R2 edge sets", 8'(rx_irq), 1);
        clr_rx = 1; tick(); clr_rx = 0;
        check("R5 clr_rx", 8'(rx_irq), 0);
        tick(); tick();
        check("R2 level no reset", 8'(rx_irq), 0);
        rx_full = 0; tick();
    endtask

    task automatic t_ovr_async();
        set_mode(3'b001);
        rx_full = 1; tick();
        clear_all();
        rx_ovr = 1; tick(); rx_ovr = 0;
        check("R3 ovr silent", 8'(rx_irq), 0);
        rx_full = 0; tick();
    endtask

    task automatic t_ovr_i2c();
        set_mode(3'b010);
        check("R4 mode readback", 8'(mode_rd), 8'h02);
        rx_full = 1; tick();
        clear_all();
        rx_ovr = 1; tick(); rx_ovr = 0;
        check("R4 i2c ovr sets", 8'(rx_irq), 1);
        set_mode(3'b000);
        check("R5 mode write keeps flag", 8'(rx_irq), 1);
        rx_full = 0; clear_all();
    endtask

    task automatic t_clear_prio();
        rx_full = 1; clr_rx = 1; tick(); clr_rx = 0;
        check("R6 rx edge beats clear", 8'(rx_irq), 1);
        rx_full = 0; clear_all();
        cond_ev = 1; tx_en = 0; set_sel(4'b0000);
        cond_ev = 0; tx_en = 1; txc_sel = 0;
        tx_empty = 1; clr_vec[0] = 1; tick(); tx_empty = 0; clr_vec[0] = 0;
        check("R6 tx event beats clear", 8'(vec_irq[0]), 1);
        clr_vec[0] = 1; tick(); clr_vec[0] = 0;
        check("R5 clr_vec", 8'(vec_irq[0]), 0);
    endtask

    task automatic t_vec0_tx();
        tx_en = 1; txc_sel = 1;
        tx_empty = 1; tick(); tx_empty = 0;
        check("R7 empty ignored when txc_sel", 8'(vec_irq[0]), 0);
        tx_cmplt = 1; tick(); tx_cmplt = 0;
        check("R7 cmplt sets", 8'(vec_irq[0]), 1);
        clear_all();
        cond_ev = 1; tick(); cond_ev = 0;
        check("R7 cond ignored sel0", 8'(vec_irq[0]), 0);
        tx_en = 0; tx_cmplt = 1; tick(); tx_cmplt = 0;
        check("R11 tx_en low blocks", 8'(vec_irq[0]), 0);
    endtask

    task automatic t_vec0_cond();
        set_sel(4'b0001);
        tx_en = 1; txc_sel = 1; tx_cmplt = 1; tick(); tx_cmplt = 0;
        check("R8 tx ignored sel1", 8'(vec_irq[0]), 0);
        cond_ev = 1; tick(); cond_ev = 0;
        check("R8 cond sets", 8'(vec_irq[0]), 1);
        set_sel(4'b0000);
        check("R12 sel change keeps flag", 8'(vec_irq[0]), 1);
        clear_all();
        tx_en = 0;
    endtask

    task automatic t_vec_peer();
        periph_ev = 3'b010; tick(); periph_ev = 0;
        check("R9 periph ignored sel0", 8'(vec_irq), 0);
        peer_tx_ev = 3'b010; tick(); peer_tx_ev = 0;
        check("R9 peer sets line2", 8'(vec_irq), 8'h04);
        clear_all();
        set_sel(4'b1000);
        check("R12 sel change no set", 8'(vec_irq), 0);
        peer_tx_ev = 3'b100; tick(); peer_tx_ev = 0;
        check("R9 peer ignored sel1", 8'(vec_irq), 0);
        periph_ev = 3'b100; tick(); periph_ev = 0;
        check("R9 periph sets line3", 8'(vec_irq), 8'h08);
        set_sel(4'b0000); clear_all();
    endtask

    task automatic t_sim();
        txc_sel = 1; err_out = 1; tx_en = 1;
        tx_buf_wr = 1; tick(); tx_buf_wr = 0;
        check("R10 wr outside SIM", 8'(vec_irq[0]), 0);
        set_mode(3'b101);
        err_out = 0; tx_buf_wr = 1; tick(); tx_buf_wr = 0;
        check("R10 err_out missing", 8'(vec_irq[0]), 0);
        err_out = 1; txc_sel = 0; tx_buf_wr = 1; tick(); tx_buf_wr = 0;
        check("R10 txc_sel missing", 8'(vec_irq[0]), 0);
        txc_sel = 1; tx_en = 0; tx_buf_wr = 1; tick(); tx_buf_wr = 0;
        check("R10 tx_en missing", 8'(vec_irq[0]), 0);
        tx_en = 1; tx_buf_wr = 1; tick(); tx_buf_wr = 0;
        check("R10 SIM start request", 8'(vec_irq[0]), 1);
        tx_en = 0; err_out = 0; txc_sel = 0;
        set_mode(3'b000); clear_all();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_rx_edge();
        t_ovr_async();
        t_ovr_i2c();
        t_clear_prio();
        t_vec0_tx();
        t_vec0_cond();
        t_vec_peer();
        t_sim();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule